// File: doc/BRIEF.md
# Banked Management Register File

This block is the register store that sits on the PHY side of a management link. A host reaches it through a simple parallel port: a 5-bit register address, 16-bit write data, one write strobe and one read strobe. Most addresses are plain 16-bit storage cells. Two addresses open indirect banks, so that the host can reach more registers than the 32 direct addresses allow.

The first indirect bank holds 32 narrow registers of 10 bits each. They share one direct address, and a single written word carries a write flag, a 5-bit bank selector and 10 data bits. A word with the flag clear only moves the selector. A word with the flag set also stores the data. The second indirect bank uses two direct addresses, one for a select value and one for a data window. The upper byte of the select value picks one of two 32-entry sub-banks (general or serial-link). The low five bits pick the entry. A select value whose upper byte names neither sub-bank, zero included, leaves the window with no target.

Read data is registered and appears one cycle after the read strobe, qualified by a valid pulse. Serial framing and the effects of individual configuration bits belong to other blocks.

Top module: `mgmt_regfile`

## Requirements
- R1: After synchronous active-high reset, `rd_valid` is 0 and every direct, shadow and expansion register reads back as 0.
- R2: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` high and 0 otherwise. `rd_data` holds the addressed value in that cycle.
- R3: Every address other than 0x15, 0x17 and 0x1C is a 16-bit register that returns the last value written to it.
- R4: A write to 0x1C with bit 15 set stores bits 9:0 into the shadow register that bits 14:10 select, and latches bits 14:10 as the current selector.
- R5: A write to 0x1C with bit 15 clear latches bits 14:10 as the selector and changes no shadow register content.
- R6: A read of 0x1C returns 0 in bit 15, the latched selector in bits 14:10 and the selected shadow register in bits 9:0.
- R7: Address 0x17 is a 16-bit expansion select register that reads back the last value written to it.
- R8: Reads and writes of 0x15 reach the general expansion bank when select bits 15:8 equal 0x0F, and the serial-link bank when they equal 0x0E. The entry index is select bits 4:0, and select bits 7:5 are ignored.
- R9: With the select value at 0, writes to 0x15 change no expansion register and reads of 0x15 return 0.
- R10: With a nonzero select value whose bits 15:8 are neither 0x0E nor 0x0F, writes to 0x15 change no expansion register and reads of 0x15 return 0.
- R11: Entry n of the general bank and entry n of the serial-link bank are separate registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` and `wdata` |
| addr | input | 5 | Direct register address |
| wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Registered read data |

## Verification
The hardest case to reach is a data-window access that has no target: a select value that is zero or names no sub-bank. Such an access must leave the stored entries alone, and that can only be seen later, once the host reselects a real sub-bank and reads the entry back. The stimulus writes known values into both sub-banks at the same index, then writes through zero and stray select values. It then reselects each sub-bank and reads the entries back. A random phase biases addresses toward the three indirect ports and biases select values toward the two sub-bank codes, with stray upper bytes and bits 7:5 set, so that the selectors move between accesses many times.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int MG_AW      = 5;
    localparam int MG_DW      = 16;
    localparam int SHD_SEL_W  = 5;
    localparam int SHD_DAT_W  = 10;
    localparam int EXP_IDX_W  = 5;
    localparam int EXP_NSUB   = 2;

    localparam logic [MG_AW-1:0] ADDR_EXP_DATA = 5'h15;
    localparam logic [MG_AW-1:0] ADDR_EXP_SEL  = 5'h17;
    localparam logic [MG_AW-1:0] ADDR_SHD      = 5'h1C;

    // Layout of the word written to / read from the shadow port.
    typedef struct packed {
        logic                 wr_flag;
        logic [SHD_SEL_W-1:0] sel;
        logic [SHD_DAT_W-1:0] data;
    } shd_word_t;

    typedef enum logic [1:0] {
        ACC_DIRECT,
        ACC_SHD,
        ACC_EXP_SEL,
        ACC_EXP_DATA
    } acc_kind_t;

    function automatic acc_kind_t classify(input logic [MG_AW-1:0] a);
        case (a)
            ADDR_SHD:      return ACC_SHD;
            ADDR_EXP_SEL:  return ACC_EXP_SEL;
            ADDR_EXP_DATA: return ACC_EXP_DATA;
            default:       return ACC_DIRECT;
        endcase
    endfunction

    // Upper-byte code of each expansion sub-bank: 0 general, 1 serial-link.
    function automatic logic [7:0] subbank_code(input int i);
        return (i == 0) ? 8'h0F : 8'h0E;
    endfunction

endpackage

// File: rtl/mgmt_direct_file.sv
module mgmt_direct_file #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/mgmt_shadow_bank.sv
module mgmt_shadow_bank #(
    parameter int SEL_W = 5,
    parameter int DAT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_wr,
    input  logic             wr_flag,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DAT_W-1:0] wr_data,
    output logic [SEL_W-1:0] cur_sel,
    output logic [DAT_W-1:0] cur_data
);
    localparam int DEPTH = 1 << SEL_W;

    logic [DAT_W-1:0] mem [DEPTH];
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (port_wr) begin
            sel_q <= wr_sel;
            if (wr_flag) mem[wr_sel] <= wr_data;
        end
    end

    assign cur_sel  = sel_q;
    assign cur_data = mem[sel_q];
endmodule

// File: rtl/mgmt_exp_bank.sv
module mgmt_exp_bank
    import mgmt_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int DW    = 16,
    parameter int NSUB  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sel_q,
    output logic [DW-1:0] win_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0]    sel_r;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    bank_rd [NSUB];

    always_ff @(posedge clk) begin
        if (rst)         sel_r <= '0;
        else if (sel_wr) sel_r <= wdata;
    end

    assign idx = sel_r[IDX_W-1:0];

    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        logic [DW-1:0] mem [DEPTH];
        logic          hit;

        assign hit = (sel_r[DW-1:DW-8] == subbank_code(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (data_wr && hit) begin
                mem[idx] <= wdata;
            end
        end

        assign bank_rd[g] = hit ? mem[idx] : '0;
    end

    always_comb begin
        win_data = '0;
        for (int i = 0; i < NSUB; i++) win_data = win_data | bank_rd[i];
    end

    assign sel_q = sel_r;
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter int AW = MG_AW,
    parameter int DW = MG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    acc_kind_t            kind;
    shd_word_t            shd_in;
    logic [DW-1:0]        dir_rd;
    logic [SHD_SEL_W-1:0] shd_sel;
    logic [SHD_DAT_W-1:0] shd_dat;
    logic [DW-1:0]        exp_sel;
    logic [DW-1:0]        exp_rd;
    logic [DW-1:0]        rd_mux;

    assign kind   = classify(addr);
    assign shd_in = shd_word_t'(wdata);

    mgmt_direct_file #(.AW(AW), .DW(DW)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && kind == ACC_DIRECT),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (dir_rd)
    );

    mgmt_shadow_bank #(.SEL_W(SHD_SEL_W), .DAT_W(SHD_DAT_W)) u_shd (
        .clk      (clk),
        .rst      (rst),
        .port_wr  (wr_en && kind == ACC_SHD),
        .wr_flag  (shd_in.wr_flag),
        .wr_sel   (shd_in.sel),
        .wr_data  (shd_in.data),
        .cur_sel  (shd_sel),
        .cur_data (shd_dat)
    );

    mgmt_exp_bank #(.IDX_W(EXP_IDX_W), .DW(DW), .NSUB(EXP_NSUB)) u_exp (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (wr_en && kind == ACC_EXP_SEL),
        .data_wr  (wr_en && kind == ACC_EXP_DATA),
        .wdata    (wdata),
        .sel_q    (exp_sel),
        .win_data (exp_rd)
    );

    always_comb begin
        case (kind)
            ACC_SHD:      rd_mux = {1'b0, shd_sel, shd_dat};
            ACC_EXP_SEL:  rd_mux = exp_sel;
            ACC_EXP_DATA: rd_mux = exp_rd;
            default:      rd_mux = dir_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/mgmt_regfile_chk.sv
module mgmt_regfile_chk
    import mgmt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [4:0]  addr,
    input logic        rd_valid,
    input logic [15:0] rd_data,
    input logic [15:0] exp_sel,
    input logic [4:0]  shd_sel
);
    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R2
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R2
    AST_SHD_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_SHD) |=> (rd_data[15] == 1'b0)); // R6
    AST_SHD_SEL_ECHO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_SHD) |=> (rd_data[14:10] == $past(shd_sel))); // R6
    AST_SHD_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_SHD) |=> $stable(shd_sel)); // R4
    AST_EXP_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_EXP_SEL) |=> $stable(exp_sel)); // R7
    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_EXP_DATA && exp_sel == 16'h0) |=> (rd_data == 16'h0)); // R9
endmodule

bind mgmt_regfile mgmt_regfile_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .exp_sel  (exp_sel),
    .shd_sel  (shd_sel)
);

// File: tb/sim_mgmt_regfile.sv
module sim_mgmt_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model
    logic [15:0] m_dir [32];
    logic [9:0]  m_shd [32];
    logic [15:0] m_gen [32];
    logic [15:0] m_ser [32];
    logic [4:0]  m_ssel;
    logic [15:0] m_esel;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_regfile u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [15:0] model_read(input logic [4:0] a);
        case (a)
            5'h1C: return {1'b0, m_ssel, m_shd[m_ssel]};
            5'h17: return m_esel;
            5'h15: begin
                if (m_esel[15:8] == 8'h0F) return m_gen[m_esel[4:0]];
                if (m_esel[15:8] == 8'h0E) return m_ser[m_esel[4:0]];
                return 16'h0;
            end
            default: return m_dir[a];
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] a);
        case (a)
            5'h1C:   return "R6";
            5'h17:   return "R7";
            5'h15:   return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            m_dir[i] = '0; m_shd[i] = '0; m_gen[i] = '0; m_ser[i] = '0;
        end
        m_ssel = '0;
        m_esel = '0;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        case (a)
            5'h1C: begin
                m_ssel = d[14:10];
                if (d[15]) m_shd[d[14:10]] = d[9:0];
            end
            5'h17: m_esel = d;
            5'h15: begin
                if (m_esel[15:8] == 8'h0F) m_gen[m_esel[4:0]] = d;
                else if (m_esel[15:8] == 8'h0E) m_ser[m_esel[4:0]] = d;
            end
            default: m_dir[a] = d;
        endcase
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] expv, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2", {15'h0, rd_valid}, 16'h1);
        check(req, rd_data, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", {15'h0, rd_valid}, 16'h0);
        rd_chk(5'h03, 16'h0, "R1");
        rd_chk(5'h1C, 16'h0, "R1");
        rd_chk(5'h17, 16'h0, "R1");
        wr(5'h17, 16'h0F07);
        rd_chk(5'h15, 16'h0, "R1");
        wr(5'h17, 16'h0E1F);
        rd_chk(5'h15, 16'h0, "R1");
        // R2: valid drops when no read is made
        @(negedge clk);
        check("R2", {15'h0, rd_valid}, 16'h0);

        // R3: direct registers
        wr(5'h00, 16'hA5A5);
        wr(5'h1F, 16'h1234);
        rd_chk(5'h00, 16'hA5A5, "R3");
        rd_chk(5'h1F, 16'h1234, "R3");

        // R4: shadow write with flag set
        wr(5'h1C, {1'b1, 5'd5, 10'h2AB});
        rd_chk(5'h1C, {1'b0, 5'd5, 10'h2AB}, "R4");
        // R5: flag clear moves selector only
        wr(5'h1C, {1'b0, 5'd5, 10'h155});
        rd_chk(5'h1C, {1'b0, 5'd5, 10'h2AB}, "R5");
        wr(5'h1C, {1'b0, 5'd9, 10'h3FF});
        rd_chk(5'h1C, {1'b0, 5'd9, 10'h000}, "R5");
        // R6: read format after write to entry 31
        wr(5'h1C, {1'b1, 5'd31, 10'h3C3});
        rd_chk(5'h1C, 16'h7FC3, "R6");

        // R7 / R8 / R11: both sub-banks at the same index
        wr(5'h17, 16'h0F05);
        wr(5'h15, 16'h1111);
        wr(5'h17, 16'h0E05);
        wr(5'h15, 16'h2222);
        rd_chk(5'h17, 16'h0E05, "R7");
        rd_chk(5'h15, 16'h2222, "R11");
        wr(5'h17, 16'h0F05);
        rd_chk(5'h15, 16'h1111, "R11");
        // R8: bits 7:5 ignored
        wr(5'h17, 16'h0FE5);
        rd_chk(5'h15, 16'h1111, "R8");

        // R9: select 0 ignores writes and reads 0
        wr(5'h17, 16'h0000);
        wr(5'h15, 16'hBEEF);
        rd_chk(5'h15, 16'h0, "R9");
        // R10: stray upper byte
        wr(5'h17, 16'h0305);
        wr(5'h15, 16'hDEAD);
        rd_chk(5'h15, 16'h0, "R10");
        wr(5'h17, 16'h0F00);
        rd_chk(5'h15, 16'h0, "R9");
        wr(5'h17, 16'h0F05);
        rd_chk(5'h15, 16'h1111, "R10");
        wr(5'h17, 16'h0E05);
        rd_chk(5'h15, 16'h2222, "R10");

        // Random phase
        for (int k = 0; k < 600; k++) begin
            logic [4:0]  a;
            logic [15:0] d;
            int          pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    a = 5'h1C;
                2, 3:    a = 5'h17;
                4, 5, 6: a = 5'h15;
                default: a = 5'($urandom_range(0, 31));
            endcase
            d = 16'($urandom);
            if (a == 5'h17) begin
                case ($urandom_range(0, 4))
                    0:       d = 16'h0;
                    1, 2:    d = {8'h0F, d[7:0]};
                    3:       d = {8'h0E, d[7:0]};
                    default: d = d;
                endcase
            end
            if ($urandom_range(0, 1) == 0) wr(a, d);
            else rd_chk(a, model_read(a), req_of(a));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule